// File: doc/BRIEF.md
# Rail Power Limit Monitor

This block watches two supply rails, a 3.3 V rail and a 12 V rail. Power readings for each rail come from an external sensor front end. Each reading is an unsigned count where one unit equals 10 mW, and it is qualified by a one-cycle valid strobe. The block keeps the newest reading of each rail and forms their 17-bit sum. It checks each rail against its own ceiling and checks the sum against a combined ceiling. When any ceiling is exceeded, it raises a shutdown request and records a cause code. The default ceilings are 970 counts for the 3.3 V rail, 3550 counts for the 12 V rail and 3775 counts for the sum. A reading equal to a ceiling is allowed.

A small controller with three states drives the shutdown. ST_IDLE is the state after reset. On the first valid strobe from either rail it moves to ST_MONITOR (transition "first reading"). ST_MONITOR moves to ST_TRIPPED on the cycle after any captured value goes over its ceiling (transition "limit exceeded"). ST_TRIPPED is left only through reset (transition "reset clear"). Reading the sensor over its serial bus is not part of this block.

Top module: `rail_power_monitor`

## Requirements
- R1: After reset both latest values and the sum read 0, the shutdown request is low and the cause code is 2'b00.
- R2: A reading strobed at a clock edge appears on its rail's latest output after that edge. Without a strobe the latest output holds its value, and this continues after a trip.
- R3: The sum output always equals the zero-extended sum of the two latest outputs, 17 bits wide, so 16'hFFFF plus 16'hFFFF reads 17'h1FFFE.
- R4: A 3.3 V latest value above 970 raises the shutdown request one cycle after the value appears, with cause 2'b01. A value of exactly 970 causes no trip.
- R5: A 12 V latest value above 3550 raises the shutdown request one cycle after the value appears, with cause 2'b10. A value of exactly 3550 causes no trip.
- R6: A sum above 3775 raises the shutdown request one cycle after it appears, with cause 2'b11. A sum of exactly 3775 causes no trip.
- R7: When several ceilings are exceeded in the same cycle, the cause follows the priority 3.3 V (2'b01) over 12 V (2'b10) over combined (2'b11).
- R8: Once raised, the shutdown request stays high and the cause code stays unchanged until reset, whatever readings follow.
- R9: A rail that has not yet delivered a reading counts as 0 in the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| v33_valid | input | 1 | Strobe for a 3.3 V rail reading |
| v33_count | input | 16 | 3.3 V rail power, 10 mW per count |
| v12_valid | input | 1 | Strobe for a 12 V rail reading |
| v12_count | input | 16 | 12 V rail power, 10 mW per count |
| v33_latest | output | 16 | Newest captured 3.3 V reading |
| v12_latest | output | 16 | Newest captured 12 V reading |
| sum_out | output | 17 | Sum of both newest readings |
| shutdown_req | output | 1 | Latched shutdown request |
| trip_cause | output | 2 | 00 none, 01 3.3 V, 10 12 V, 11 combined |

## Verification
Each rail is driven to exactly its ceiling and then one count over it. This separates a strict comparison from an inclusive one. The combined ceiling is tested with both rails inside their own limits, so a sum-only trip cannot be mistaken for a rail trip. Same-cycle double violations show the cause priority. Readings that go back below the limits after a trip, or that exceed a different limit, show that the latch and the cause hold. A strobe on only one rail shows that the other rail holds its value and counts as zero before its first reading. An all-ones pair shows that the sum keeps its carry bit.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
    localparam int NUM_RAILS = 2;
    localparam int RAIL_LO   = 0;
    localparam int RAIL_HI   = 1;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_RAIL_LO  = 2'b01,
        CAUSE_RAIL_HI  = 2'b10,
        CAUSE_COMBINED = 2'b11
    } trip_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_MONITOR = 2'b01,
        ST_TRIPPED = 2'b10
    } mon_state_e;
endpackage

// File: rtl/rpm_rail_capture.sv
module rpm_rail_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_valid,
    input  logic [W-1:0] rd_count,
    output logic [W-1:0] latest
);
    // Holding register; zero until the first reading so an unseen rail adds nothing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latest <= '0;
        end else if (rd_valid) begin
            latest <= rd_count;
        end
    end
endmodule

// File: rtl/rpm_limit_compare.sv
module rpm_limit_compare #(
    parameter int W       = 16,
    parameter int LIM_LO  = 970,
    parameter int LIM_HI  = 3550,
    parameter int LIM_SUM = 3775
) (
    input  logic [W-1:0] lo_val,
    input  logic [W-1:0] hi_val,
    output logic [W:0]   sum,
    output logic         over_lo,
    output logic         over_hi,
    output logic         over_sum
);
    localparam int SUMW = W + 1;
    localparam logic [W-1:0]    LIM_LO_V  = W'(LIM_LO);
    localparam logic [W-1:0]    LIM_HI_V  = W'(LIM_HI);
    localparam logic [SUMW-1:0] LIM_SUM_V = SUMW'(LIM_SUM);

    always_comb begin
        sum      = {1'b0, lo_val} + {1'b0, hi_val};
        over_lo  = lo_val > LIM_LO_V;
        over_hi  = hi_val > LIM_HI_V;
        over_sum = sum > LIM_SUM_V;
    end
endmodule

// File: rtl/rpm_trip_fsm.sv
module rpm_trip_fsm
    import rpm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        any_valid,
    input  logic        over_lo,
    input  logic        over_hi,
    input  logic        over_sum,
    output logic        shutdown,
    output trip_cause_e cause
);
    mon_state_e  state_q, state_d;
    trip_cause_e cause_q, cause_d;
    trip_cause_e first_cause;

    // Priority encode the violations seen this cycle
    always_comb begin
        if (over_lo) begin
            first_cause = CAUSE_RAIL_LO;
        end else if (over_hi) begin
            first_cause = CAUSE_RAIL_HI;
        end else if (over_sum) begin
            first_cause = CAUSE_COMBINED;
        end else begin
            first_cause = CAUSE_NONE;
        end
    end

    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_valid) begin
                    state_d = ST_MONITOR;
                end
            end
            ST_MONITOR: begin
                if (first_cause != CAUSE_NONE) begin
                    state_d = ST_TRIPPED;
                    cause_d = first_cause;
                end
            end
            ST_TRIPPED: begin
                state_d = ST_TRIPPED;
            end
            default: begin
                state_d = ST_IDLE;
                cause_d = CAUSE_NONE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // Outputs
    always_comb begin
        shutdown = (state_q == ST_TRIPPED);
        cause    = cause_q;
    end
endmodule

// File: rtl/rail_power_monitor.sv
module rail_power_monitor
    import rpm_pkg::*;
#(
    parameter int W       = 16,
    parameter int LIM_LO  = 970,
    parameter int LIM_HI  = 3550,
    parameter int LIM_SUM = 3775
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v33_valid,
    input  logic [15:0]  v33_count,
    input  logic         v12_valid,
    input  logic [15:0]  v12_count,
    output logic [15:0]  v33_latest,
    output logic [15:0]  v12_latest,
    output logic [16:0]  sum_out,
    output logic         shutdown_req,
    output logic [1:0]   trip_cause
);
    logic [NUM_RAILS-1:0]        rail_vld;
    logic [NUM_RAILS-1:0][W-1:0] rail_cnt;
    logic [NUM_RAILS-1:0][W-1:0] rail_latest;
    logic                        over_lo, over_hi, over_sum;
    logic [W:0]                  sum_w;
    trip_cause_e                 cause_e;

    assign rail_vld[RAIL_LO] = v33_valid;
    assign rail_vld[RAIL_HI] = v12_valid;
    assign rail_cnt[RAIL_LO] = v33_count;
    assign rail_cnt[RAIL_HI] = v12_count;

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        rpm_rail_capture #(.W(W)) u_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_valid (rail_vld[g]),
            .rd_count (rail_cnt[g]),
            .latest   (rail_latest[g])
        );
    end

    rpm_limit_compare #(
        .W(W), .LIM_LO(LIM_LO), .LIM_HI(LIM_HI), .LIM_SUM(LIM_SUM)
    ) u_cmp (
        .lo_val   (rail_latest[RAIL_LO]),
        .hi_val   (rail_latest[RAIL_HI]),
        .sum      (sum_w),
        .over_lo  (over_lo),
        .over_hi  (over_hi),
        .over_sum (over_sum)
    );

    rpm_trip_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_valid (|rail_vld),
        .over_lo   (over_lo),
        .over_hi   (over_hi),
        .over_sum  (over_sum),
        .shutdown  (shutdown_req),
        .cause     (cause_e)
    );

    assign v33_latest = rail_latest[RAIL_LO];
    assign v12_latest = rail_latest[RAIL_HI];
    assign sum_out    = sum_w;
    assign trip_cause = cause_e;
endmodule

// File: rtl/rpm_checker.sv
module rpm_checker #(
    parameter int LIM_LO  = 970,
    parameter int LIM_HI  = 3550,
    parameter int LIM_SUM = 3775
) (
    input logic        clk,
    input logic        rst_n,
    input logic        v33_valid,
    input logic [15:0] v33_count,
    input logic        v12_valid,
    input logic [15:0] v12_count,
    input logic [15:0] v33_latest,
    input logic [15:0] v12_latest,
    input logic [16:0] sum_out,
    input logic        shutdown_req,
    input logic [1:0]  trip_cause
);
    AST_CAPTURE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        v33_valid |=> v33_latest == $past(v33_count)); // R2
    AST_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        !v12_valid |=> $stable(v12_latest)); // R2
    AST_SUM_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        sum_out == ({1'b0, v33_latest} + {1'b0, v12_latest})); // R3
    AST_TRIP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown_req && v33_latest > 16'(LIM_LO)) |=> (shutdown_req && trip_cause == 2'b01)); // R4
    AST_NO_TRIP_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown_req && v33_latest <= 16'(LIM_LO) && v12_latest <= 16'(LIM_HI)
         && sum_out <= 17'(LIM_SUM)) |=> !shutdown_req); // R6
    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> (shutdown_req && $stable(trip_cause))); // R8
    AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown_req |-> trip_cause == 2'b00); // R1
endmodule

bind rail_power_monitor rpm_checker #(
    .LIM_LO(LIM_LO), .LIM_HI(LIM_HI), .LIM_SUM(LIM_SUM)
) u_rpm_chk (
    .clk(clk), .rst_n(rst_n), .v33_valid(v33_valid), .v33_count(v33_count),
    .v12_valid(v12_valid), .v12_count(v12_count), .v33_latest(v33_latest),
    .v12_latest(v12_latest), .sum_out(sum_out), .shutdown_req(shutdown_req),
    .trip_cause(trip_cause)
);

// File: tb/tb_rail_power_monitor.sv
module tb_rail_power_monitor;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v33_valid = 1'b0;
    logic [15:0] v33_count = '0;
    logic        v12_valid = 1'b0;
    logic [15:0] v12_count = '0;
    logic [15:0] v33_latest, v12_latest;
    logic [16:0] sum_out;
    logic        shutdown_req;
    logic [1:0]  trip_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_power_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .v33_valid(v33_valid), .v33_count(v33_count),
        .v12_valid(v12_valid), .v12_count(v12_count),
        .v33_latest(v33_latest), .v12_latest(v12_latest),
        .sum_out(sum_out), .shutdown_req(shutdown_req), .trip_cause(trip_cause)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        v33_valid = 1'b0;
        v12_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drives a strobe at a falling edge; returns at the next falling edge,
    // when the captured values are visible and a trip is one edge away
    task automatic apply(bit lv, int lo, bit hv, int hi);
        v33_valid = lv;
        v33_count = 16'(lo);
        v12_valid = hv;
        v12_count = 16'(hi);
        @(negedge clk);
        v33_valid = 1'b0;
        v12_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 lo latest", 32'(v33_latest), 0);
        check("R1 hi latest", 32'(v12_latest), 0);
        check("R1 sum", 32'(sum_out), 0);
        check("R1 shutdown", 32'(shutdown_req), 0);
        check("R1 cause", 32'(trip_cause), 0);
    endtask

    task automatic t_capture_hold();
        do_reset();
        apply(1, 500, 0, 0);
        check("R2 lo captured", 32'(v33_latest), 500);
        check("R2 R9 hi untouched", 32'(v12_latest), 0);
        check("R9 sum with unseen rail", 32'(sum_out), 500);
        apply(0, 777, 1, 1200);
        check("R2 lo held", 32'(v33_latest), 500);
        check("R2 hi captured", 32'(v12_latest), 1200);
        check("R3 sum", 32'(sum_out), 1700);
        @(negedge clk);
        check("R2 no trip", 32'(shutdown_req), 0);
    endtask

    task automatic t_limit_lo();
        do_reset();
        apply(1, 970, 0, 0);
        @(negedge clk);
        check("R4 at limit", 32'(shutdown_req), 0);
        apply(1, 971, 0, 0);
        check("R4 not yet", 32'(shutdown_req), 0);
        @(negedge clk);
        check("R4 trip", 32'(shutdown_req), 1);
        check("R4 cause", 32'(trip_cause), 1);
    endtask

    task automatic t_limit_hi();
        do_reset();
        apply(0, 0, 1, 3550);
        @(negedge clk);
        check("R5 R9 at limit", 32'(shutdown_req), 0);
        apply(0, 0, 1, 3551);
        @(negedge clk);
        check("R5 trip", 32'(shutdown_req), 1);
        check("R5 cause", 32'(trip_cause), 2);
    endtask

    task automatic t_combined();
        do_reset();
        apply(1, 900, 1, 2875);
        check("R6 sum at limit", 32'(sum_out), 3775);
        @(negedge clk);
        check("R6 at limit", 32'(shutdown_req), 0);
        apply(0, 0, 1, 2876);
        @(negedge clk);
        check("R6 trip", 32'(shutdown_req), 1);
        check("R6 cause", 32'(trip_cause), 3);
    endtask

    task automatic t_priority();
        do_reset();
        apply(1, 1000, 1, 3600);
        @(negedge clk);
        check("R7 lo over hi", 32'(trip_cause), 1);
        do_reset();
        apply(1, 200, 1, 3600);
        @(negedge clk);
        check("R7 hi over combined", 32'(trip_cause), 2);
    endtask

    task automatic t_latch();
        do_reset();
        apply(0, 0, 1, 3700);
        @(negedge clk);
        check("R8 tripped", 32'(trip_cause), 2);
        apply(1, 1000, 0, 0);
        repeat (2) @(negedge clk);
        check("R8 cause kept", 32'(trip_cause), 2);
        apply(1, 10, 1, 20);
        check("R2 updates after trip", 32'(v12_latest), 20);
        repeat (5) @(negedge clk);
        check("R8 shutdown kept", 32'(shutdown_req), 1);
        check("R8 cause still", 32'(trip_cause), 2);
        do_reset();
        check("R1 reset clears", 32'(shutdown_req), 0);
    endtask

    task automatic t_wide_sum();
        do_reset();
        apply(1, 16'hFFFF, 1, 16'hFFFF);
        check("R3 carry kept", 32'(sum_out), 32'h1FFFE);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_capture_hold();
        t_limit_lo();
        t_limit_hi();
        t_combined();
        t_priority();
        t_latch();
        t_wide_sum();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule